// File: doc/BRIEF.md
# Load/Store Execution Unit

This unit carries out the data-movement subset of a 16-bit instruction set. It receives one instruction word and the already-incremented program counter, then forms an effective address. The address comes from the incremented PC plus a 9-bit signed offset, or from a base register plus a 6-bit signed offset, or it is the value itself for the address-only instruction. A short multi-cycle sequencer then drives a synchronous, word-addressed 16-bit memory port. The unit holds eight 16-bit general registers and a three-bit sign condition code.

The two indirect forms chain two memory accesses. The first read fetches a pointer. The indirect load then reads through that pointer, and the indirect store writes through it. The address-only instruction writes its computed address into a register and makes no memory access. A surrounding pipeline presents `start` with an instruction while `ready` is high, and it waits for the one-cycle `done` pulse.

Top module: `ldst_unit`

## Requirements
- R1: After reset `ready` is 1, `done`, `mem_rd` and `mem_wr` are 0, `cc` is 3'b010, and all eight registers hold 0.
- R2: `instr[15:12]` is the opcode. `instr[11:9]` names the destination register of a load or address instruction, and the source register of a store.
- R3: Opcode 4'b1110 writes `pc_inc` + sign-extended `instr[8:0]` into the named register and makes no memory access. For example, `pc_inc` 0x4019 with offset -3 gives 0x4016.
- R4: Opcodes 4'b0010 (load) and 4'b0011 (store) make exactly one access, at `pc_inc` + sign-extended `instr[8:0]`. A load copies the read word into the register. A store writes the whole register to memory.
- R5: Opcodes 4'b0110 (load) and 4'b0111 (store) make exactly one access, at register `instr[8:6]` + sign-extended `instr[5:0]`. The sum wraps modulo 2^16. With a base of 0x2345 and offset 0x1D, the access goes to 0x2362.
- R6: Opcode 4'b1010 first reads the PC-relative address, then reads the address returned by that first read. The second word goes to the destination register.
- R7: Opcode 4'b1011 reads a pointer at the PC-relative address, then writes the source register to the address held in the pointer. It makes exactly one read and one write.
- R8: Every register write sets `cc`, with bit 2 for negative, bit 1 for zero and bit 0 for positive. Stores leave `cc` unchanged.
- R9: `done` is high for exactly one cycle. Counting the accepting clock edge, it appears after 2 edges for the address instruction and for illegal opcodes, 3 for direct loads and stores, and 4 for both indirect forms. `ready` returns in the following cycle.
- R10: `start` is acted on only while `ready` is high. A `start` during a running instruction has no effect on the accesses or the result.
- R11: Any other opcode pulses `illegal` together with `done`. Such an opcode makes no memory access and changes neither the registers nor `cc`.
- R12: `mem_rd` and `mem_wr` are never high together. Read data is taken from `mem_rdata` in the cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present (accepted while ready) |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter of that instruction |
| ready | output | 1 | Idle, able to accept an instruction |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unsupported opcode, valid with done |
| cc | output | 3 | Condition code {N,Z,P} |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_rd |

## Verification
The hardest situation to reach from the ports is a chained indirect access whose pointer is correct only if the pointer read is consumed in exactly the right cycle. The same is true of a `start` pulse that arrives while such a chain is running. Registers can be observed only through later stores and through `cc`. The stimulus therefore first seeds every register through the address instruction. It then runs a long, seeded random mix of all seven opcodes and the illegal ones against a memory model that returns a distinct word for every address. This way a stale or misrouted pointer always shows up as a wrong address. Directed cases add the two worked examples, address wraparound, a zero and a negative result, and a stray `start` pulse injected in the middle of an indirect load.

// File: rtl/ldst_unit.sv
module ldst_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] instr,
  input  logic [15:0] pc_inc,
  output logic        ready,
  output logic        done,
  output logic        illegal,
  output logic [2:0]  cc,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata
);
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_LEA = 4'b1110;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_READ1, S_READ2, S_WRITE, S_DONE} state_t;

  state_t      st, nxt;
  logic [15:0] ir, pcq, ea;
  logic [15:0] rf [8];

  wire [3:0]  op  = ir[15:12];
  wire [2:0]  rix = ir[11:9];
  wire [2:0]  bix = ir[8:6];
  wire [15:0] off9 = {{7{ir[8]}}, ir[8:0]};
  wire [15:0] off6 = {{10{ir[5]}}, ir[5:0]};

  wire is_ldi  = op == OP_LDI;
  wire is_sti  = op == OP_STI;
  wire is_lea  = op == OP_LEA;
  wire is_base = (op == OP_LDR) || (op == OP_STR);
  wire is_load = (op == OP_LD) || (op == OP_LDR) || is_ldi;
  wire is_str  = (op == OP_ST) || (op == OP_STR) || is_sti;
  wire legal   = is_load || is_str || is_lea;

  wire [15:0] ea_calc = is_base ? rf[bix] + off6 : pcq + off9;
  wire        wen     = (st == S_DONE) && (is_load || is_lea);
  wire [15:0] wval    = is_lea ? ea : mem_rdata;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:  if (start) nxt = S_ADDR;
      S_ADDR:  if (is_lea || !legal) nxt = S_DONE;
               else if (is_load || is_sti) nxt = S_READ1;
               else nxt = S_WRITE;
      S_READ1: nxt = is_ldi ? S_READ2 : (is_sti ? S_WRITE : S_DONE);
      S_READ2: nxt = S_DONE;
      S_WRITE: nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ir  <= '0;
      pcq <= '0;
      ea  <= '0;
      cc  <= 3'b010;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        ir  <= instr;
        pcq <= pc_inc;
      end
      if (st == S_ADDR) ea <= ea_calc;
      if (wen) begin
        rf[rix] <= wval;
        cc <= wval[15] ? 3'b100 : (wval == 16'h0 ? 3'b010 : 3'b001);
      end
    end
  end

  assign ready     = st == S_IDLE;
  assign done      = st == S_DONE;
  assign illegal   = done && !legal;
  assign mem_rd    = (st == S_READ1) || (st == S_READ2);
  assign mem_wr    = st == S_WRITE;
  assign mem_addr  = ((st == S_READ2) || (st == S_WRITE && is_sti)) ? mem_rdata : ea;
  assign mem_wdata = rf[rix];

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> ready);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (ready && start) |=> !ready);
  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R11
  illegal_cc_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> $stable(cc));
  // R11
  illegal_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> $past(!mem_rd && !mem_wr));
endmodule

// File: tb/ldst_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_unit_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] instr = 0, pc_inc = 0, mem_rdata = 0;
  logic ready, done, illegal, mem_rd, mem_wr;
  logic [2:0] cc;
  logic [15:0] mem_addr, mem_wdata;

  ldst_unit dut_i (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_inc(pc_inc),
    .ready(ready), .done(done), .illegal(illegal), .cc(cc), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  logic [15:0] mem [logic [15:0]];
  int nrd, nwr;
  logic [15:0] raddr [4];
  logic [15:0] waddr, wdata;
  logic [15:0] ref_r [8];
  logic [2:0]  ref_cc;

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [2:0] cc_f(input logic [15:0] v);
    return v[15] ? 3'b100 : (v == 0 ? 3'b010 : 3'b001);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_f(mem_addr);
      if (nrd < 4) raddr[nrd] = mem_addr;
      nrd++;
    end
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      waddr = mem_addr;
      wdata = mem_wdata;
      nwr++;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] ins, input logic [15:0] pci, input bit poke);
    logic [3:0] op;
    logic [2:0] dr, br;
    logic [15:0] off9, off6, ea, p, e_val, e_r0, e_r1, e_wa, e_wd;
    int e_nrd, e_nwr, e_lat, lat;
    bit e_ill, e_wen;
    string rq;
    op = ins[15:12]; dr = ins[11:9]; br = ins[8:6];
    off9 = {{7{ins[8]}}, ins[8:0]};
    off6 = {{10{ins[5]}}, ins[5:0]};
    e_nrd = 0; e_nwr = 0; e_ill = 0; e_wen = 0; e_val = 0;
    e_r0 = 0; e_r1 = 0; e_wa = 0; e_wd = 0; e_lat = 2;
    case (op)
      4'h2: begin rq = "R4"; ea = pci + off9; e_nrd = 1; e_r0 = ea; e_wen = 1; e_val = mem_f(ea); e_lat = 3; end
      4'h3: begin rq = "R4"; ea = pci + off9; e_nwr = 1; e_wa = ea; e_wd = ref_r[dr]; e_lat = 3; end
      4'h6: begin rq = "R5"; ea = ref_r[br] + off6; e_nrd = 1; e_r0 = ea; e_wen = 1; e_val = mem_f(ea); e_lat = 3; end
      4'h7: begin rq = "R5"; ea = ref_r[br] + off6; e_nwr = 1; e_wa = ea; e_wd = ref_r[dr]; e_lat = 3; end
      4'hA: begin rq = "R6"; ea = pci + off9; p = mem_f(ea); e_nrd = 2; e_r0 = ea; e_r1 = p;
                  e_wen = 1; e_val = mem_f(p); e_lat = 4; end
      4'hB: begin rq = "R7"; ea = pci + off9; p = mem_f(ea); e_nrd = 1; e_r0 = ea;
                  e_nwr = 1; e_wa = p; e_wd = ref_r[dr]; e_lat = 4; end
      4'hE: begin rq = "R3"; e_wen = 1; e_val = pci + off9; end
      default: begin rq = "R11"; e_ill = 1; end
    endcase
    @(negedge clk);
    nrd = 0; nwr = 0;
    start = 1; instr = ins; pc_inc = pci;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 0;
      if (poke && lat == 2) begin start = 1; instr = 16'h3E05; pc_inc = 16'h1111; end
      if (done) break;
    end
    chk("R9", "latency", lat, e_lat);
    chk(e_ill ? "R11" : "R2", "illegal", illegal, e_ill);
    chk(rq, "reads", nrd, e_nrd);
    if (e_nrd > 0) chk(rq, "read addr 1", raddr[0], e_r0);
    if (e_nrd > 1) chk(rq, "read addr 2", raddr[1], e_r1);
    chk(rq, "writes", nwr, e_nwr);
    if (e_nwr > 0) begin
      chk(rq, "write addr", waddr, e_wa);
      chk(rq, "write data", wdata, e_wd);
    end
    @(negedge clk);
    start = 0;
    chk("R9", "done pulse end", done, 0);
    chk("R9", "ready after done", ready, 1);
    if (e_wen) begin ref_r[dr] = e_val; ref_cc = cc_f(e_val); end
    chk(e_wen ? "R8" : (e_ill ? "R11" : "R8"), "cc", cc, ref_cc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [3:0] op;
    logic [3:0] legal_ops [7];
    legal_ops = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE};
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 8; i++) ref_r[i] = 0;
    ref_cc = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready", ready, 1);
    chk("R1", "done", done, 0);
    chk("R1", "mem_rd", mem_rd, 0);
    chk("R1", "cc", cc, 3'b010);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mem_wr", mem_wr, 0);
    for (int r = 0; r < 8; r++) exec(16'h3000 | (16'(r) << 9), 16'h0100, 0);

    exec(16'hEBFD, 16'h4019, 0);
    exec(16'h3A10, 16'h0800, 0);
    chk("R3", "worked address value", wdata, 16'h4016);
    exec(16'hE400, 16'h2345, 0);
    exec(16'h629D, 16'h0000, 0);
    chk("R5", "worked base+offset address", raddr[0], 16'h2362);
    exec(16'hE600, 16'hFFF0, 0);
    exec(16'h7ADF, 16'h0000, 0);
    chk("R5", "wrap address", waddr, 16'h000F);
    exec(16'hE000, 16'h0000, 0);
    chk("R8", "zero code", cc, 3'b010);
    exec(16'hE000, 16'h8000, 0);
    chk("R8", "negative code", cc, 3'b100);
    exec(16'h9000, 16'h1234, 0);
    chk("R11", "cc kept", cc, 3'b100);
    exec(16'hA805, 16'h3000, 1);
    chk("R10", "no stray write", nwr, 0);
    exec(16'hB605, 16'h3000, 0);

    for (int i = 0; i < 8; i++) exec(16'hE000 | (16'(i) << 9), 16'($urandom), 0);
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 9) < 9) op = legal_ops[$urandom_range(0, 6)];
      else op = 4'($urandom_range(0, 15));
      exec({op, 12'($urandom)}, 16'($urandom), ($urandom_range(0, 19) == 0));
    end
    for (int r = 0; r < 8; r++) begin
      exec(16'h3000 | (16'(r) << 9), 16'h0200, 0);
      chk("R2", "final register", wdata, ref_r[r]);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule